// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block moves received frames from a byte stream into memory under control of a ring of descriptors that software prepares. When a frame begins, it reads the four words of the current descriptor. Word 0 carries the ownership flag. Word 1 carries the control bits and the buffer size. Word 2 holds the buffer address and word 3 the next-descriptor address. The block then packs the frame bytes into 32-bit words and writes them into the buffer. Last, it writes a status word back into word 0 with ownership cleared. That word holds the stored length and the completion and error flags.

Each frame is expected to fit a single buffer. When a frame is longer than the buffer, the engine stores only the bytes that fit and marks the frame as truncated. When the descriptor is still held by software, the engine discards the whole frame and raises a buffer-unavailable flag. The next frame then tries the same descriptor again. A small register port starts and stops the engine, selects one of two descriptor control layouts and loads the ring base address. The same port reports two write-one-to-clear status flags, which drive one interrupt line.

Top module: `rx_ring_writer`

## Requirements
- R1: While control bit 0 (run, register address 0) is clear, an idle engine keeps s_ready low and issues no memory request. Setting run lets the next frame start. Control bit 1 selects the layout of word 1.
- R2: At the start of a frame, the engine reads four words at the current descriptor address plus 0, 4, 8 and 12, in that order. Word 2 is the buffer byte address and word 3 is the next-descriptor address.
- R3: Frame byte n is written to byte lane n mod 4 (bits 8k+7:8k) of the word at buffer + 4*(n/4). Unused lanes of the final written word are zero, and no word past the stored bytes is written.
- R4: After the last byte is stored, the engine writes word 0 at the descriptor address with the following layout:
  - bit 31 is 0;
  - bits 29:16 hold the byte count, which includes the 4-byte check sequence;
  - bits 9 and 8 are both 1;
  - all other bits are 0 unless an error flag applies.
- R5: A frame longer than the buffer size keeps only its first size bytes. The stored length equals the size, and bit 12 (length error) and bit 15 (error summary) are set.
- R6: If s_err is high on any accepted byte of a frame, bit 1 (check-sequence error) and bit 15 are set in its writeback word. Bit 15 is the OR of bits 12 and 1.
- R7: If word 0 bit 31 of the fetched descriptor is clear, the engine handles the case as follows:
  - it reads no further word of that descriptor;
  - it accepts and discards the whole frame without any memory write;
  - it sets status bit 1;
  - it fetches the same descriptor again for the next frame.
- R8: After writeback, the engine picks the next descriptor address in this order:
  - if the chained bit is set, it takes word 3;
  - else if the end-of-ring bit is set, it takes the base register;
  - otherwise it takes the current address plus 16.
- R9: With control bit 1 clear, word 1 has interrupt-disable at bit 31, end-of-ring at bit 25, chained at bit 24 and size at bits 10:0. With control bit 1 set, end-of-ring is at bit 15, chained at bit 14 and size at bits 12:0, and interrupt-disable stays at bit 31. Bits outside the selected fields have no effect.
- R10: Status bit 0 (receive complete, register address 2) is set when a writeback is accepted, unless word 1 bit 31 was set. Writing 1 to a status bit clears it. irq is high while any status bit is set.
- R11: A memory request that is not accepted (mem_ready low) is held with unchanged address, write enable and write data in the next cycle.
- R12: A write to register address 1 loads the base address and also moves the current descriptor pointer to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 base, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | High while any status bit is set |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_err | input | 1 | Frame error indication for this byte |
| s_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions rely on two properties of the memory. It returns exactly one read response for every accepted read, and never an unsolicited one. They also assume that no frame buffer overlaps a descriptor, so that a write to the current descriptor address is always the writeback. The bench's memory model answers each read one cycle after it is accepted. The model withholds mem_ready on a fixed rotating phase, so held requests occur. Descriptors and buffers are placed in separate regions of the model. Stream bytes are offered only between frames or in response to s_ready, and the run bit is changed only while no frame is pending.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int WORD_W      = 32;
    localparam int LEN_W       = 14;
    localparam int SIZE_W      = 13;
    localparam int NORM_SIZE_W = 11;
    localparam int DESC_STRIDE = 16;
    localparam int IDX_W       = LEN_W - 2;

    // writeback word positions
    localparam int BIT_OWN = 31;
    localparam int LEN_LSB = 16;
    localparam int BIT_ES  = 15;
    localparam int BIT_LE  = 12;
    localparam int BIT_FS  = 9;
    localparam int BIT_LS  = 8;
    localparam int BIT_CE  = 1;

    // control word positions
    localparam int C_NOIRQ = 31;
    localparam int N_EOR   = 25;
    localparam int N_CHAIN = 24;
    localparam int E_EOR   = 15;
    localparam int E_CHAIN = 14;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DROP,
        ST_FILL,
        ST_WBACK
    } rx_state_e;

    typedef struct packed {
        logic              no_irq;
        logic              ring_end;
        logic              chained;
        logic [SIZE_W-1:0] size;
    } rx_ctl_t;

    function automatic rx_ctl_t decode_ctl(input logic enh, input logic [WORD_W-1:0] w);
        rx_ctl_t c;
        c.no_irq = w[C_NOIRQ];
        if (enh) begin
            c.ring_end = w[E_EOR];
            c.chained  = w[E_CHAIN];
            c.size     = w[SIZE_W-1:0];
        end else begin
            c.ring_end = w[N_EOR];
            c.chained  = w[N_CHAIN];
            c.size     = SIZE_W'(w[NORM_SIZE_W-1:0]);
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_wb(input logic [LEN_W-1:0] len,
                                                  input logic trunc, input logic crc);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        w[BIT_ES] = trunc | crc;
        w[BIT_LE] = trunc;
        w[BIT_FS] = 1'b1;
        w[BIT_LS] = 1'b1;
        w[BIT_CE] = crc;
        return w;
    endfunction

endpackage

// File: rtl/rxw_regs.sv
module rxw_regs
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              run,
    output logic              enh,
    output logic [ADDR_W-1:0] base,
    output logic              base_load,
    output logic [ADDR_W-1:0] base_val,
    input  logic              done_set,
    input  logic              nobuf_set,
    output logic              irq
);

    logic [1:0] stat_q;
    logic [1:0] stat_clr;
    logic [1:0] stat_set;

    assign stat_clr  = (reg_wr && reg_addr == RA_STAT) ? reg_wdata[1:0] : 2'b00;
    assign stat_set  = {nobuf_set, done_set};
    assign base_load = reg_wr && reg_addr == RA_BASE;
    assign base_val  = reg_wdata[ADDR_W-1:0];
    assign irq       = |stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            enh    <= 1'b0;
            base   <= '0;
            stat_q <= 2'b00;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) begin
                run <= reg_wdata[0];
                enh <= reg_wdata[1];
            end
            if (base_load) base <= base_val;
            stat_q <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {30'd0, enh, run};
            RA_BASE: reg_rdata = WORD_W'(base);
            RA_STAT: reg_rdata = {30'd0, stat_q};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxw_packer.sv
module rxw_packer
    import rxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        din,
    input  logic              last,
    input  logic [SIZE_W-1:0] limit,
    input  logic              flush_ack,
    output logic              flush_req,
    output logic [WORD_W-1:0] flush_word,
    output logic [IDX_W-1:0]  flush_idx,
    output logic [LEN_W-1:0]  stored,
    output logic              trunc
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_next;
    logic              room;
    logic              word_end;

    assign room     = stored < LEN_W'(limit);
    assign acc_next = acc_q | (WORD_W'(din) << {stored[1:0], 3'b000});
    assign word_end = (stored[1:0] == 2'd3) || last || (stored + 1'b1 == LEN_W'(limit));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q      <= '0;
            stored     <= '0;
            trunc      <= 1'b0;
            flush_req  <= 1'b0;
            flush_word <= '0;
            flush_idx  <= '0;
        end else begin
            if (flush_ack) flush_req <= 1'b0;
            if (take) begin
                if (room) begin
                    stored <= stored + 1'b1;
                    if (word_end) begin
                        flush_req  <= 1'b1;
                        flush_word <= acc_next;
                        flush_idx  <= stored[LEN_W-1:2];
                        acc_q      <= '0;
                    end else begin
                        acc_q <= acc_next;
                    end
                end else begin
                    trunc <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              enh,
    input  logic [ADDR_W-1:0] base,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              pk_clear,
    output logic              pk_take,
    output logic [SIZE_W-1:0] pk_limit,
    output logic              pk_flush_ack,
    input  logic              pk_flush_req,
    input  logic [WORD_W-1:0] pk_flush_word,
    input  logic [IDX_W-1:0]  pk_flush_idx,
    input  logic [LEN_W-1:0]  pk_stored,
    input  logic              pk_trunc,
    output logic              done_set,
    output logic              nobuf_set,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              is_idle
);

    rx_state_e         state_q;
    logic [1:0]        idx_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] buf_q;
    logic [ADDR_W-1:0] next_q;
    rx_ctl_t           ctl_q;
    logic              crc_q;
    logic              last_q;
    logic [ADDR_W-1:0] nxt_desc;

    assign cur_desc  = cur_q;
    assign is_idle   = state_q == ST_IDLE;
    assign pk_clear  = state_q == ST_IDLE;
    assign pk_limit  = ctl_q.size;
    assign s_ready   = (state_q == ST_DROP) ||
                       (state_q == ST_FILL && !pk_flush_req && !last_q);
    assign pk_take   = state_q == ST_FILL && s_valid && s_ready;
    assign pk_flush_ack = state_q == ST_FILL && pk_flush_req && mem_ready;
    assign nobuf_set = state_q == ST_WAIT && mem_rvalid && idx_q == 2'd0 && !mem_rdata[BIT_OWN];
    assign done_set  = state_q == ST_WBACK && mem_ready && !ctl_q.no_irq;
    assign nxt_desc  = ctl_q.chained  ? next_q :
                       ctl_q.ring_end ? base   : cur_q + ADDR_W'(DESC_STRIDE);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + ADDR_W'({idx_q, 2'b00});
            end
            ST_FILL: begin
                mem_req   = pk_flush_req;
                mem_we    = 1'b1;
                mem_addr  = buf_q + ADDR_W'({pk_flush_idx, 2'b00});
                mem_wdata = pk_flush_word;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = pack_wb(pk_stored, pk_trunc, crc_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= 2'd0;
            cur_q   <= '0;
            buf_q   <= '0;
            next_q  <= '0;
            ctl_q   <= '0;
            crc_q   <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run && s_valid) begin
                        state_q <= ST_FETCH;
                        idx_q   <= 2'd0;
                    end
                end
                ST_FETCH: begin
                    if (mem_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        case (idx_q)
                            2'd1:    ctl_q  <= decode_ctl(enh, mem_rdata);
                            2'd2:    buf_q  <= mem_rdata[ADDR_W-1:0];
                            2'd3:    next_q <= mem_rdata[ADDR_W-1:0];
                            default: ;
                        endcase
                        if (idx_q == 2'd0 && !mem_rdata[BIT_OWN]) begin
                            state_q <= ST_DROP;
                        end else if (idx_q == 2'd3) begin
                            state_q <= ST_FILL;
                            crc_q   <= 1'b0;
                            last_q  <= 1'b0;
                        end else begin
                            idx_q   <= idx_q + 2'd1;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_DROP: begin
                    if (s_valid && s_last) state_q <= ST_IDLE;
                end
                ST_FILL: begin
                    if (pk_take) begin
                        crc_q <= crc_q | s_err;
                        if (s_last) last_q <= 1'b1;
                    end
                    if (last_q && !pk_flush_req) state_q <= ST_WBACK;
                end
                ST_WBACK: begin
                    if (mem_ready) begin
                        state_q <= ST_IDLE;
                        cur_q   <= nxt_desc;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (base_load) cur_q <= base_val;
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);

    logic              run, enh, base_load;
    logic [ADDR_W-1:0] base, base_val;
    logic              done_set, nobuf_set;
    logic              pk_clear, pk_take, pk_flush_ack, pk_flush_req, pk_trunc;
    logic [SIZE_W-1:0] pk_limit;
    logic [WORD_W-1:0] pk_flush_word;
    logic [IDX_W-1:0]  pk_flush_idx;
    logic [LEN_W-1:0]  pk_stored;
    logic [ADDR_W-1:0] cur_desc_w;
    logic              is_idle_w;

    rxw_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .run       (run),
        .enh       (enh),
        .base      (base),
        .base_load (base_load),
        .base_val  (base_val),
        .done_set  (done_set),
        .nobuf_set (nobuf_set),
        .irq       (irq)
    );

    rxw_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .clear      (pk_clear),
        .take       (pk_take),
        .din        (s_data),
        .last       (s_last),
        .limit      (pk_limit),
        .flush_ack  (pk_flush_ack),
        .flush_req  (pk_flush_req),
        .flush_word (pk_flush_word),
        .flush_idx  (pk_flush_idx),
        .stored     (pk_stored),
        .trunc      (pk_trunc)
    );

    rxw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .enh           (enh),
        .base          (base),
        .base_load     (base_load),
        .base_val      (base_val),
        .s_valid       (s_valid),
        .s_last        (s_last),
        .s_err         (s_err),
        .s_ready       (s_ready),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ready     (mem_ready),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .pk_clear      (pk_clear),
        .pk_take       (pk_take),
        .pk_limit      (pk_limit),
        .pk_flush_ack  (pk_flush_ack),
        .pk_flush_req  (pk_flush_req),
        .pk_flush_word (pk_flush_word),
        .pk_flush_idx  (pk_flush_idx),
        .pk_stored     (pk_stored),
        .pk_trunc      (pk_trunc),
        .done_set      (done_set),
        .nobuf_set     (nobuf_set),
        .cur_desc      (cur_desc_w),
        .is_idle       (is_idle_w)
    );

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [ADDR_W-1:0] cur_desc,
    input logic [SIZE_W-1:0] cur_size,
    input logic              is_idle,
    input logic              run,
    input logic              s_ready,
    input logic              irq,
    input logic              reg_wr
);

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_own_clear_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr == cur_desc |-> !mem_wdata[BIT_OWN] && mem_wdata[BIT_FS] && mem_wdata[BIT_LS]);

    p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr == cur_desc |-> mem_wdata[LEN_LSB +: LEN_W] <= LEN_W'(cur_size));

    p_summary_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr == cur_desc |-> mem_wdata[BIT_ES] == (mem_wdata[BIT_LE] | mem_wdata[BIT_CE]));

    p_stopped_r1: assert property (@(posedge clk) disable iff (rst)
        is_idle && !run |-> !mem_req && !s_ready);

    p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(reg_wr));

endmodule

bind rx_ring_writer rxw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cur_desc  (cur_desc_w),
    .cur_size  (pk_limit),
    .is_idle   (is_idle_w),
    .run       (run),
    .s_ready   (s_ready),
    .irq       (irq),
    .reg_wr    (reg_wr)
);

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq;
    logic        s_valid, s_last, s_err, s_ready;
    logic [7:0]  s_data;
    logic        mem_req, mem_we, mem_ready, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem_arr [0:255];
    logic [1:0]  rdy_ph = 2'd0;
    int          rd_cnt = 0;
    int          hold_bad = 0;
    logic        stall_q = 1'b0;
    logic [31:0] addr_q, wd_q;
    logic        we_q;

    int total = 0;
    int bad = 0;
    int exp_cur = 0;
    int base_v = 0;
    bit enh_mode = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err),
        .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model: accepts when ready, answers reads one cycle later
    assign mem_ready = (rdy_ph != 2'd2);
    always @(negedge clk) rdy_ph <= rdy_ph + 2'd1;

    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req && mem_ready) begin
                if (mem_we) mem_arr[mem_addr[9:2]] <= mem_wdata;
                else begin
                    mem_rdata  <= mem_arr[mem_addr[9:2]];
                    mem_rvalid <= 1'b1;
                    rd_cnt     <= rd_cnt + 1;
                end
            end
        end
    end

    // R11 request hold monitor
    always @(posedge clk) begin
        if (!rst && stall_q &&
            (!mem_req || mem_addr != addr_q || mem_wdata != wd_q || mem_we != we_q))
            hold_bad <= hold_bad + 1;
        stall_q <= !rst && mem_req && !mem_ready;
        addr_q  <= mem_addr;
        wd_q    <= mem_wdata;
        we_q    <= mem_we;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input logic [7:0] b, input logic lst, input logic er);
        logic got;
        s_valid = 1'b1; s_data = b; s_last = lst; s_err = er;
        got = 1'b0;
        while (!got) begin
            got = s_ready;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    endtask

    function automatic logic [7:0] fbyte(input int len, input int i);
        return 8'((len * 13 + i * 7 + 1) & 255);
    endfunction

    function automatic logic [31:0] ctl_word(input int size, input bit dic,
                                             input bit chain, input bit eor);
        logic [31:0] w;
        w = 32'(size);
        w[31] = dic;
        if (enh_mode) begin w[15] = eor; w[14] = chain; end
        else          begin w[25] = eor; w[24] = chain; end
        return w;
    endfunction

    // one frame against the descriptor the bench expects to be current
    task automatic do_frame(input int len, input int size, input bit err, input bit dic,
                            input bit chain, input bit eor, input int nextp,
                            input bit owned, input logic [31:0] junk);
        int bufa, rd0, stored, nw, d;
        bit tr;
        logic [31:0] ew, st;
        d      = exp_cur >> 2;
        bufa   = 32'h200 + (exp_cur >> 4) * 32;
        stored = (len < size) ? len : size;
        tr     = len > size;
        nw     = (stored + 3) / 4;
        mem_arr[d]     = owned ? 32'h8000_0000 : 32'h0;
        mem_arr[d + 1] = ctl_word(size, dic, chain, eor) | junk;
        mem_arr[d + 2] = bufa;
        mem_arr[d + 3] = nextp;
        for (int w = 0; w < 8; w++) mem_arr[(bufa >> 2) + w] = 32'hA5A5_0000 | w;
        rd0 = rd_cnt;
        for (int i = 0; i < len; i++) push(fbyte(len, i), i == len - 1, err && i == len / 2);
        if (owned) begin
            for (int t = 0; t < 3000 && mem_arr[d][31]; t++) @(negedge clk);
            repeat (2) @(negedge clk);
            ew = (32'(stored) << 16) | (32'(tr | err) << 15) | (32'(tr) << 12) |
                 32'h300 | (32'(err) << 1);
            // R4 length/flags, R5 truncation, R6 error flag
            chk(tr ? "R5 writeback" : (err ? "R6 writeback" : "R4 writeback"), mem_arr[d], ew);
            for (int w = 0; w < 8; w++) begin
                if (w < nw) begin
                    ew = '0;
                    for (int l = 0; l < 4; l++)
                        if (4 * w + l < stored) ew[8*l +: 8] = fbyte(len, 4 * w + l);
                end else ew = 32'hA5A5_0000 | w;
                chk("R3 buffer word", mem_arr[(bufa >> 2) + w], ew);
            end
            chk("R2 descriptor reads", rd_cnt - rd0, 4);
            reg_read(2'd2, st);
            chk("R10 status after frame", st, dic ? 32'd0 : 32'd1);
            chk("R10 irq", {31'd0, irq}, dic ? 32'd0 : 32'd1);
            exp_cur = chain ? nextp : (eor ? base_v : exp_cur + 16);
        end else begin
            repeat (3) @(negedge clk);
            chk("R7 descriptor untouched", mem_arr[d], 32'h0);
            chk("R7 buffer untouched", mem_arr[bufa >> 2], 32'hA5A5_0000);
            chk("R7 single read", rd_cnt - rd0, 1);
            reg_read(2'd2, st);
            chk("R7 unavailable status", st, 32'd2);
        end
        @(negedge clk);
        reg_write(2'd2, 32'd3);
        reg_read(2'd2, st);
        chk("R10 cleared by write-one", st, 32'd0);
        chk("R10 irq low", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int viol;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        s_valid = 1'b0; s_data = '0; s_last = 1'b0; s_err = 1'b0;
        for (int i = 0; i < 256; i++) mem_arr[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk("R1 reset s_ready", {31'd0, s_ready}, 0);
        chk("R1 reset mem_req", {31'd0, mem_req}, 0);
        chk("R10 reset irq", {31'd0, irq}, 0);
        reg_read(2'd2, r);
        chk("R10 reset status", r, 0);

        // R1: not running, a pending byte is not taken
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1;
        viol = 0;
        for (int c = 0; c < 12; c++) begin
            if (s_ready || mem_req) viol++;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        chk("R1 stopped engine quiet", viol, 0);

        reg_write(2'd1, 32'h0);   // R12 base = 0
        base_v = 0; exp_cur = 0;
        reg_write(2'd0, 32'd1);   // run, normal layout
        reg_read(2'd0, r);
        chk("R1 control readback", r, 1);

        // sweep of lengths around word and buffer boundaries; ring of 4 wraps at 0x30 (R8)
        for (int len = 1; len <= 26; len++) begin
            do_frame(len, (len % 3 == 0) ? 12 : 20, len % 5 == 0, len % 7 == 0,
                     1'b0, exp_cur == 32'h30, 0, 1'b1, 32'h0);
        end

        // R9: size field bit 11 set in normal layout is outside the field, so the size is 16
        do_frame(20, 16, 1'b0, 1'b0, 1'b0, exp_cur == 32'h30, 0, 1'b1, 32'h0000_0800);

        // R8: chained descriptor jumps to 0x80, then chains back to 0x10
        do_frame(9, 20, 1'b0, 1'b0, 1'b1, 1'b0, 32'h80, 1'b1, 32'h0);
        chk("R8 chain target", exp_cur, 32'h80);
        do_frame(5, 20, 1'b0, 1'b0, 1'b1, 1'b0, 32'h10, 1'b1, 32'h0);
        chk("R8 chain used word 3", mem_arr[32'h80 >> 2], 32'h0005_0300);

        // R7: not owned, then retried on the same descriptor
        do_frame(7, 20, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 32'h0);
        do_frame(7, 20, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 32'h0);
        chk("R7 retry landed", mem_arr[32'h10 >> 2], 32'h0007_0300);

        // R9: enhanced layout; normal-layout position bits set as junk must be ignored
        reg_write(2'd0, 32'd3);
        enh_mode = 1;
        do_frame(11, 24, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 32'h0300_0000);
        chk("R9 enhanced advance by 16", exp_cur, 32'h30);
        do_frame(24, 22, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b1, 32'h0);
        chk("R9 enhanced end of ring", exp_cur, 32'h0);
        do_frame(13, 24, 1'b0, 1'b1, 1'b1, 1'b0, 32'h40, 1'b1, 32'h0);
        chk("R9 enhanced chain", exp_cur, 32'h40);

        // R12: stop, load a new base, restart
        reg_write(2'd0, 32'd0);
        enh_mode = 0;
        reg_write(2'd1, 32'hC0);
        base_v = 32'hC0; exp_cur = 32'hC0;
        reg_write(2'd0, 32'd1);
        do_frame(6, 20, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b1, 32'h0);
        chk("R12 frame at new base", mem_arr[32'hC0 >> 2], 32'h0006_0300);
        chk("R12 ring end returns to base", exp_cur, 32'hC0);

        // R1: stop again, offered byte is not accepted
        reg_write(2'd0, 32'd0);
        s_valid = 1'b1; s_data = 8'hAA; s_last = 1'b1;
        viol = 0;
        for (int c = 0; c < 12; c++) begin
            if (s_ready || mem_req) viol++;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        chk("R1 stop holds engine", viol, 0);

        chk("R11 held requests stable", hold_bad, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule